// File: doc/BRIEF.md
# Integrating Tick Input Filter

This block cleans up one asynchronous, clock-like input, such as an external time-base tick, before it drives downstream counters. The raw pin first passes through a chain of flip-flops on the system clock. The synchronized level is then sampled only on a strobe. The strobe is either a prescaled filter strobe shared with other inputs, or a divide-by-two strobe made inside the block.

Two filters act on the samples. The first is a saturating two-bit up/down integrator with hysteretic output. The second accepts a new level only after two consecutive samples agree on it. A mode input picks which filter drives the output. Both filters keep tracking the samples at all times, so a switch between modes never clears their state. The block presents the filtered level and a single-cycle pulse on each rising edge of that level.

Top module: `tick_input_filter`

## Requirements
- R1: The raw input reaches the filter only through two flip-flops on the system clock. The synchronized level equals the raw input as it was two clock edges earlier.
- R2: The integrator count, the two-sample history and the filtered level change only on a clock edge where the selected strobe is asserted.
- R3: `strobe_sel_i` = 0 selects `ext_strobe_i` as the strobe. `strobe_sel_i` = 1 selects an internal strobe that is asserted on every second clock cycle.
- R4: On each strobe, the integrator count rises by one for a high sample and falls by one for a low sample. It saturates at 3 and at 0. After any number of high samples, exactly three low samples bring the count back to 0.
- R5: With `mode_sel_i` = 0 (integrator), `level_o` becomes 1 when the count reaches 3 and becomes 0 when the count reaches 0. At counts 1 and 2 it keeps its previous value.
- R6: With `mode_sel_i` = 1 (two-sample), `level_o` takes a new value only when the current strobe sample and the previous strobe sample are equal and differ from `level_o`.
- R7: While `rst_ni` is low, the count, the two-sample history, `level_o` and `rise_o` are 0.
- R8: `rise_o` is high for exactly one cycle: the first cycle in which `level_o` is 1 after being 0.
- R9: Changing `mode_sel_i` leaves the integrator count and `level_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_i | input | 1 | Asynchronous tick input from the pin |
| strobe_sel_i | input | 1 | Strobe source: 0 = shared strobe, 1 = internal divide-by-two |
| mode_sel_i | input | 1 | Filter mode: 0 = integrator, 1 = two-sample |
| ext_strobe_i | input | 1 | Shared prescaled filter strobe |
| level_o | output | 1 | Filtered level |
| rise_o | output | 1 | One-cycle pulse on each rising edge of `level_o` |

## Verification
Two events can fall in the same clock edge: the integrator count reaching its limit and the output update that depends on it. The rise pulse then follows in the same cycle as the new level. The bench provokes this by feeding a third high sample after two high samples, and by feeding high samples past saturation. It then checks that the level and the pulse appear together, after exactly one strobe, and never earlier. A mode change placed between two strobes mid-count is judged by counting how many further high samples are needed before the level rises.

// File: rtl/tif_pkg.sv
package tif_pkg;

  typedef enum logic {
    MODE_INTEG = 1'b0,
    MODE_PAIR  = 1'b1
  } filt_mode_e;

  typedef enum logic {
    SRC_SHARED = 1'b0,
    SRC_HALF   = 1'b1
  } strobe_src_e;

  // Two-sample rule: accept a new level when both samples agree on it
  function automatic logic pair_level(input logic smp, input logic hist,
                                      input logic lvl);
    logic res;
    res = lvl;
    if ((smp == hist) && (smp != lvl)) res = smp;
    return res;
  endfunction

  // Rising-edge test on a level and its delayed copy
  function automatic logic rise_of(input logic now_lvl, input logic old_lvl);
    return now_lvl & ~old_lvl;
  endfunction

endpackage

// File: rtl/tif_sync.sv
module tif_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[0] <= 1'b0;
          else         chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= 1'b0;
          else         chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/tif_strobe_gen.sv
module tif_strobe_gen
  import tif_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic ext_strobe_i,
  output logic strobe_o,
  output logic half_o
);
  logic toggle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) toggle_q <= 1'b0;
    else         toggle_q <= ~toggle_q;
  end

  assign half_o = toggle_q;

  always_comb begin
    unique case (strobe_src_e'(src_i))
      SRC_HALF:   strobe_o = toggle_q;
      default:    strobe_o = ext_strobe_i;
    endcase
  end
endmodule

// File: rtl/tif_core.sv
module tif_core
  import tif_pkg::*;
#(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic             smp_i,
  input  logic             mode_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hist_o,
  output logic             level_o
);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  // Saturating up/down step
  function automatic logic [CNT_W-1:0] integ_step(input logic [CNT_W-1:0] c,
                                                  input logic up);
    logic [CNT_W-1:0] r;
    r = c;
    if (up && (c != CNT_MAX))        r = c + CNT_ONE;
    else if (!up && (c != CNT_ZERO)) r = c - CNT_ONE;
    return r;
  endfunction

  // Hysteretic level from the updated count
  function automatic logic integ_level(input logic [CNT_W-1:0] c,
                                       input logic lvl);
    logic r;
    r = lvl;
    if (c == CNT_MAX)       r = 1'b1;
    else if (c == CNT_ZERO) r = 1'b0;
    return r;
  endfunction

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hist_q;
  logic             level_q, level_d;

  always_comb begin
    cnt_d = integ_step(cnt_q, smp_i);
    unique case (filt_mode_e'(mode_i))
      MODE_PAIR: level_d = pair_level(smp_i, hist_q, level_q);
      default:   level_d = integ_level(cnt_d, level_q);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= CNT_ZERO;
      hist_q  <= 1'b0;
      level_q <= 1'b0;
    end else if (strobe_i) begin
      cnt_q   <= cnt_d;
      hist_q  <= smp_i;
      level_q <= level_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign hist_o  = hist_q;
  assign level_o = level_q;
endmodule

// File: rtl/tick_input_filter.sv
module tick_input_filter
  import tif_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  input  logic strobe_sel_i,
  input  logic mode_sel_i,
  input  logic ext_strobe_i,
  output logic level_o,
  output logic rise_o
);
  // Named internal events for the checker
  logic             sync_w;
  logic             strobe_w;
  logic             half_w;
  logic [CNT_W-1:0] cnt_w;
  logic             hist_w;
  logic             level_w;
  logic             level_prev_q;

  tif_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_i),
    .q_o   (sync_w)
  );

  tif_strobe_gen u_strobe (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_i       (strobe_sel_i),
    .ext_strobe_i(ext_strobe_i),
    .strobe_o    (strobe_w),
    .half_o      (half_w)
  );

  tif_core #(.CNT_W(CNT_W)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(strobe_w),
    .smp_i   (sync_w),
    .mode_i  (mode_sel_i),
    .cnt_o   (cnt_w),
    .hist_o  (hist_w),
    .level_o (level_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_prev_q <= 1'b0;
    else         level_prev_q <= level_w;
  end

  assign level_o = level_w;
  assign rise_o  = rise_of(level_w, level_prev_q);
endmodule

// File: rtl/tif_checker.sv
module tif_checker #(
  parameter int unsigned CNT_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             raw_i,
  input logic             strobe_sel_i,
  input logic             mode_sel_i,
  input logic             sync_w,
  input logic             strobe_w,
  input logic             half_w,
  input logic [CNT_W-1:0] cnt_w,
  input logic             hist_w,
  input logic             level_o,
  input logic             rise_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [1:0] since_rst_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 since_rst_q <= 2'd0;
    else if (since_rst_q != 2'd3) since_rst_q <= since_rst_q + 2'd1;
  end

  assert_sync_delay_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst_q == 2'd3) |-> (sync_w == $past(raw_i, 2)));

  assert_hold_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_w |=> $stable(cnt_w) && $stable(hist_w));

  assert_hold_level_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_w |=> $stable(level_o));

  assert_half_alternates_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_sel_i && strobe_w) |=> !half_w);

  assert_sat_top_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_w && sync_w && cnt_w == CNT_MAX) |=> (cnt_w == CNT_MAX));

  assert_sat_bottom_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_w && !sync_w && cnt_w == '0) |=> (cnt_w == '0));

  assert_reach_top_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_sel_i && strobe_w && sync_w && cnt_w == CNT_MAX - 1'b1) |=> level_o);

  assert_reach_bottom_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_sel_i && strobe_w && !sync_w && cnt_w == 1) |=> !level_o);

  assert_pair_agree_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_sel_i && strobe_w && sync_w == hist_w) |=> (level_o == $past(sync_w)));

  assert_rise_with_level_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> level_o);

  assert_rise_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_clear_R7: assert (cnt_w == '0 && !hist_w && !level_o && !rise_o);
    end
  end
endmodule

bind tick_input_filter tif_checker #(.CNT_W(CNT_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .raw_i       (raw_i),
  .strobe_sel_i(strobe_sel_i),
  .mode_sel_i  (mode_sel_i),
  .sync_w      (sync_w),
  .strobe_w    (strobe_w),
  .half_w      (half_w),
  .cnt_w       (cnt_w),
  .hist_w      (hist_w),
  .level_o     (level_o),
  .rise_o      (rise_o)
);

// File: tb/tick_input_filter_tb_top.sv
module tick_input_filter_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic raw = 1'b0;
  logic strobe_sel = 1'b0;
  logic mode_sel = 1'b0;
  logic ext_strobe = 1'b0;
  logic level;
  logic rise;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  tick_input_filter dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .raw_i       (raw),
    .strobe_sel_i(strobe_sel),
    .mode_sel_i  (mode_sel),
    .ext_strobe_i(ext_strobe),
    .level_o     (level),
    .rise_o      (rise)
  );

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; raw = 1'b0; ext_strobe = 1'b0;
    strobe_sel = 1'b0; mode_sel = 1'b0;
    step(3);
    rst_ni = 1'b1;
    step(1);
  endtask

  // Let the level settle through the synchronizer, then pulse one strobe;
  // return at the negedge right after the updating edge.
  task automatic feed(input logic v);
    raw = v;
    step(2);
    ext_strobe = 1'b1;
    step(1);
    ext_strobe = 1'b0;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; raw = 1'b1; ext_strobe = 1'b1;
    step(4);
    check("R7 level in reset", level, 1'b0);
    check("R7 rise in reset", rise, 1'b0);
    do_reset();
  endtask

  task automatic t_integrator();
    do_reset();
    feed(1'b1); check("R5 count1 holds 0", level, 1'b0);
    feed(1'b1); check("R5 count2 holds 0", level, 1'b0);
    feed(1'b1); check("R5 count3 sets 1", level, 1'b1);
    check("R8 rise with new level", rise, 1'b1);
    step(1); check("R8 rise one cycle", rise, 1'b0);
    feed(1'b0); check("R5 count2 holds 1", level, 1'b1);
    feed(1'b1); check("R5 back to 3 stays 1", level, 1'b1);
    check("R8 no rise when already high", rise, 1'b0);
    feed(1'b0); feed(1'b0);
    check("R5 count1 holds 1", level, 1'b1);
    feed(1'b0); check("R5 count0 clears", level, 1'b0);
  endtask

  task automatic t_glitch();
    do_reset();
    for (int i = 0; i < 6; i++) feed(i[0] ? 1'b0 : 1'b1);
    check("R5 alternating samples rejected", level, 1'b0);
  endtask

  task automatic t_saturate();
    do_reset();
    for (int i = 0; i < 6; i++) feed(1'b1);
    check("R4 high after many highs", level, 1'b1);
    feed(1'b0); feed(1'b0);
    check("R4 two lows keep level", level, 1'b1);
    feed(1'b0);
    check("R4 third low reaches zero", level, 1'b0);
    for (int i = 0; i < 5; i++) feed(1'b0);
    feed(1'b1); feed(1'b1);
    check("R4 floor saturated, two highs", level, 1'b0);
    feed(1'b1);
    check("R4 third high reaches top", level, 1'b1);
  endtask

  task automatic t_no_strobe();
    do_reset();
    raw = 1'b1;
    step(20);
    check("R2 no strobe no change", level, 1'b0);
    feed(1'b1); feed(1'b1);
    check("R2 only strobes counted", level, 1'b0);
  endtask

  task automatic t_pair();
    do_reset();
    mode_sel = 1'b1;
    step(1);
    feed(1'b1); check("R6 single high ignored", level, 1'b0);
    feed(1'b1); check("R6 two highs accepted", level, 1'b1);
    check("R8 rise in two-sample mode", rise, 1'b1);
    feed(1'b0); check("R6 lone low ignored", level, 1'b1);
    feed(1'b1); feed(1'b0);
    check("R6 mixed samples ignored", level, 1'b1);
    feed(1'b0); check("R6 two lows accepted", level, 1'b0);
  endtask

  task automatic t_mode_switch();
    do_reset();
    feed(1'b1); feed(1'b1);
    check("R9 count2 level low", level, 1'b0);
    mode_sel = 1'b1; step(3);
    mode_sel = 1'b0; step(1);
    check("R9 switch keeps level", level, 1'b0);
    feed(1'b1);
    check("R9 count kept across switch", level, 1'b1);
  endtask

  task automatic t_half_strobe();
    int first_hi;
    do_reset();
    strobe_sel = 1'b1;
    raw = 1'b1;
    first_hi = -1;
    for (int i = 1; i <= 10; i++) begin
      step(1);
      if (level && first_hi < 0) first_hi = i;
    end
    check("R3 divide-by-two not before edge 7", (first_hi >= 7) ? 1'b1 : 1'b0, 1'b1);
    check("R3 divide-by-two by edge 8", (first_hi >= 0 && first_hi <= 8) ? 1'b1 : 1'b0, 1'b1);
  endtask

  task automatic t_sync_delay();
    do_reset();
    // raw high for one cycle only, strobe on the following edge: too early
    raw = 1'b1;
    ext_strobe = 1'b1;
    step(1);
    ext_strobe = 1'b0;
    raw = 1'b0;
    step(3);
    feed(1'b1); feed(1'b1);
    check("R1 early sample not counted", level, 1'b0);
    feed(1'b1);
    check("R1 three synchronized highs", level, 1'b1);
  endtask

  initial begin
    t_reset();
    t_integrator();
    t_glitch();
    t_saturate();
    t_no_strobe();
    t_pair();
    t_mode_switch();
    t_half_strobe();
    t_sync_delay();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule